// File: doc/BRIEF.md
# Next-Fetch Address Predictor

This block sits beside an instruction fetch stage and names the address to fetch in the following cycle. Each cycle it receives the current fetch address. It compares that address against a two-way set-associative table that only ever records branches seen to be taken. On a match, the recorded destination becomes the next fetch address, so a correctly predicted taken branch costs no fetch cycle. On a miss the fetch simply moves on by one word, to the current address plus 4.

On a miss, a much larger direct-mapped array of two-bit saturating counters gives a separate taken/not-taken opinion. When a branch resolves, the update port trains both structures. A flush input empties the destination table in one cycle when the address space changes. A small circular stack of return addresses predicts the destinations of subroutine returns:
- A call pushes the address that follows it.
- A return pops that address and overrides the other sources.

Top module: `bp_next_fetch`

## Requirements
- R1: After reset, every lookup misses (`pred_btb_hit`=0). The next address is `fetch_pc`+4. `pred_taken` is 0 because all counters start at 1. The return stack is empty.
- R2: When the destination table misses and no pop is requested, `pred_next_pc` equals `fetch_pc`+4 in the same cycle.
- R3: A resolved taken branch (`upd_valid`=1, `upd_taken`=1) that misses is allocated. From the next cycle, a lookup of that address hits and `pred_next_pc` equals its `upd_target`.
- R4: The destination table has 128 sets of 2 ways.
  - The set index is address bits [8:2] and the tag is bits [31:9].
  - One LRU bit per set points at the way to replace. Any taken update touching a way makes that way most recent.
  - A third taken branch in a full set evicts the least recent way. No two valid ways of a set match the same address.
- R5: A resolved not-taken branch that hits has its entry invalidated. From the next cycle that address misses, and the other way of the set is kept.
- R6: `flush`=1 invalidates every entry of the destination table for the next cycle. A same-cycle update of that table is dropped. The counters and the return stack are not affected.
- R7: The counter array has 2048 two-bit counters indexed by address bits [12:2].
  - Each resolved branch moves its counter up on taken and down on not-taken, saturating at 3 and at 0.
  - On a miss, `pred_taken` is bit 1 of the counter, so 2 and 3 mean taken. On a hit, `pred_taken` is 1.
- R8: `call_push`=1 stores `fetch_pc`+4 on the return stack. `ret_pop`=1 on a non-empty stack makes `pred_next_pc` the most recently pushed address (last in, first out) and sets `pred_from_ras`. This takes priority over a destination-table hit.
- R9: The return stack holds 8 addresses. A push onto a full stack overwrites the oldest entry, so the following 8 pops return the 8 newest addresses.
- R10: A pop on an empty stack predicts `fetch_pc`+4, even on a destination-table hit, and leaves the stack empty.
- R11: A push and a pop in the same cycle predict the current top. The top is then replaced by the new return address, and the depth is unchanged.
- R12: A taken update that hits an existing entry replaces the stored destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Current fetch address (word aligned) |
| call_push | input | 1 | Current fetch is a call: push `fetch_pc`+4 |
| ret_pop | input | 1 | Current fetch is a return: pop and predict |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual destination of the resolved branch |
| flush | input | 1 | Address-space change: empty the destination table |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_btb_hit | output | 1 | Destination table matched `fetch_pc` |
| pred_taken | output | 1 | Direction opinion (hit, or counter bit 1 on miss) |
| pred_from_ras | output | 1 | `pred_next_pc` comes from the return stack |

## Verification
The bench drives a loop trace through a few iterations and its exit, then probes the corner cases directly.
- **Set conflicts:** three branches share set 0. A design with a wrong LRU sense evicts the most recently trained branch instead of the stale one.
- **Counter saturation:** a counter is walked past both ends. A design that wraps at either end turns a strongly held direction into its opposite.
- **Stack overflow and underflow:** nine calls are made onto an eight-deep stack, then more returns than entries. A design that refuses the overflow push, or pops past the bottom, returns stale addresses instead of the newest eight and the fall-through.
- **Simultaneous actions:** a flush coincides with an allocation, and a push coincides with a pop. Wrong priority here either leaves a live entry after an address-space change or corrupts the stack depth.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BTB = 2'd1,
    SRC_RAS = 2'd2
  } nxt_src_e;

  localparam logic [1:0] CTR_INIT = 2'b01;

  // saturating two-bit step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == 2'b11) ? cur : cur + 2'b01;
    else    res = (cur == 2'b00) ? cur : cur - 2'b01;
    return res;
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bp_target_table.sv
module bp_target_table #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [1:0]        lk_way_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              flush
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - SET_W;
  localparam int WAYS  = 2;

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0]           lru_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [ADDR_W-1:0]         tgt_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  up_way_hit;

  assign lk_set = lk_pc[2 +: SET_W];
  assign lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
  assign up_set = upd_pc[2 +: SET_W];
  assign up_tag = upd_pc[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lk_way_hit[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_way_hit[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  assign lk_hit    = |lk_way_hit;
  assign lk_target = lk_way_hit[1] ? tgt_q[lk_set][1] : tgt_q[lk_set][0];

  // next-state decisions
  logic wr_en, inv_en, lru_we, lru_d, wr_way;

  always_comb begin
    wr_en  = 1'b0;
    inv_en = 1'b0;
    lru_we = 1'b0;
    lru_d  = 1'b0;
    wr_way = 1'b0;
    if (upd_valid && !flush) begin
      if (upd_taken) begin
        wr_en  = 1'b1;
        wr_way = (|up_way_hit) ? up_way_hit[1] : lru_q[up_set];
        lru_we = 1'b1;
        lru_d  = ~wr_way;
      end else if (|up_way_hit) begin
        inv_en = 1'b1;
        wr_way = up_way_hit[1];
        lru_we = 1'b1;
        lru_d  = up_way_hit[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
      lru_q <= '0;
    end else begin
      if (wr_en || inv_en) vld_q[up_set][wr_way] <= wr_en;
      if (lru_we)          lru_q[up_set]         <= lru_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_set][wr_way] <= up_tag;
      tgt_q[up_set][wr_way] <= upd_target;
    end
  end
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_pc
);
  import bp_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0][1:0] ctr_q;
  logic [IDX_W-1:0]        lk_idx, up_idx;
  logic [1:0]              ctr_d;
  logic                    ctr_en;

  assign lk_idx   = lk_pc[2 +: IDX_W];
  assign up_idx   = upd_pc[2 +: IDX_W];
  assign lk_taken = ctr_q[lk_idx][1];

  always_comb begin
    ctr_en = upd_valid;
    ctr_d  = ctr_step(ctr_q[up_idx], upd_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (ctr_en) begin
      ctr_q[up_idx] <= ctr_d;
    end
  end
endmodule

// File: rtl/bp_return_stack.sv
module bp_return_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8   // power of two
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [ADDR_W-1:0]          push_addr,
  input  logic                       pop,
  output logic                       empty,
  output logic [ADDR_W-1:0]          top_addr,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, top_idx, wr_idx;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, wr_en;

  assign top_idx  = wp_q - PTR_W'(1);
  assign empty    = (cnt_q == '0);
  assign top_addr = mem_q[top_idx];
  assign count    = cnt_q;
  assign do_pop   = pop && !empty;

  always_comb begin
    wp_d   = wp_q;
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    wr_idx = wp_q;
    if (push && do_pop) begin
      wr_en  = 1'b1;
      wr_idx = top_idx;
    end else if (push) begin
      wr_en  = 1'b1;
      wp_d   = wp_q + PTR_W'(1);
      cnt_d  = (cnt_q == FULL) ? cnt_q : cnt_q + CNT_W'(1);
    end else if (do_pop) begin
      wp_d   = top_idx;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= push_addr;
  end
endmodule

// File: rtl/bp_next_fetch.sv
module bp_next_fetch #(
  parameter int ADDR_W      = 32,
  parameter int BTB_SETS    = 128,
  parameter int BHT_ENTRIES = 2048,
  parameter int RAS_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              call_push,
  input  logic              ret_pop,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              flush,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_btb_hit,
  output logic              pred_taken,
  output logic              pred_from_ras
);
  import bp_pkg::*;
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  logic              rst_q_n;
  logic              btb_hit, bht_taken, ras_empty;
  logic [1:0]        btb_way_hit;
  logic [ADDR_W-1:0] btb_target, ras_top, seq_pc;
  logic [CNT_W-1:0]  ras_count;
  nxt_src_e          src;

  bp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  bp_target_table #(.ADDR_W(ADDR_W), .SETS(BTB_SETS)) u_btb (
    .clk(clk), .rst_n(rst_q_n),
    .lk_pc(fetch_pc), .lk_hit(btb_hit), .lk_way_hit(btb_way_hit), .lk_target(btb_target),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pc(upd_pc),
    .upd_target(upd_target), .flush(flush)
  );

  bp_counter_table #(.ADDR_W(ADDR_W), .ENTRIES(BHT_ENTRIES)) u_bht (
    .clk(clk), .rst_n(rst_q_n),
    .lk_pc(fetch_pc), .lk_taken(bht_taken),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pc(upd_pc)
  );

  assign seq_pc = fetch_pc + ADDR_W'(4);

  bp_return_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst_n(rst_q_n),
    .push(call_push), .push_addr(seq_pc), .pop(ret_pop),
    .empty(ras_empty), .top_addr(ras_top), .count(ras_count)
  );

  always_comb begin
    if (ret_pop)      src = ras_empty ? SRC_SEQ : SRC_RAS;
    else if (btb_hit) src = SRC_BTB;
    else              src = SRC_SEQ;
  end

  always_comb begin
    case (src)
      SRC_RAS: pred_next_pc = ras_top;
      SRC_BTB: pred_next_pc = btb_target;
      default: pred_next_pc = seq_pc;
    endcase
  end

  assign pred_btb_hit  = btb_hit;
  assign pred_taken    = btb_hit | bht_taken;
  assign pred_from_ras = (src == SRC_RAS);
endmodule

// File: rtl/bp_next_fetch_chk.sv
module bp_next_fetch_chk #(
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              fetch_pc,
  input logic                           ret_pop,
  input logic                           upd_valid,
  input logic                           upd_taken,
  input logic [ADDR_W-1:0]              upd_pc,
  input logic [ADDR_W-1:0]              upd_target,
  input logic                           flush,
  input logic [ADDR_W-1:0]              pred_next_pc,
  input logic                           pred_btb_hit,
  input logic [1:0]                     way_hit,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_count
);
  AST_TAKEN_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !flush) |=>
      ((fetch_pc != $past(upd_pc)) || ret_pop ||
       (pred_btb_hit && pred_next_pc == $past(upd_target)))); // R3

  AST_NOT_TAKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !pred_btb_hit)); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_btb_hit); // R6

  AST_WAY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R4

  AST_RAS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ras_count <= ($clog2(RAS_DEPTH+1))'(RAS_DEPTH)); // R9

  AST_POP_EMPTY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && ras_count == '0) |-> (pred_next_pc == fetch_pc + ADDR_W'(4))); // R10
endmodule

bind bp_next_fetch bp_next_fetch_chk #(.ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_q_n), .fetch_pc(fetch_pc), .ret_pop(ret_pop),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pc(upd_pc),
  .upd_target(upd_target), .flush(flush), .pred_next_pc(pred_next_pc),
  .pred_btb_hit(pred_btb_hit), .way_hit(btb_way_hit), .ras_count(ras_count)
);

// File: tb/test_bp_next_fetch.sv
module test_bp_next_fetch;
  logic        clk, rst_n;
  logic [31:0] fetch_pc, upd_pc, upd_target;
  logic        call_push, ret_pop, upd_valid, upd_taken, flush;
  logic [31:0] pred_next_pc;
  logic        pred_btb_hit, pred_taken, pred_from_ras;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bp_next_fetch i_bp_next_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .call_push(call_push),
    .ret_pop(ret_pop), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .flush(flush), .pred_next_pc(pred_next_pc),
    .pred_btb_hit(pred_btb_hit), .pred_taken(pred_taken), .pred_from_ras(pred_from_ras)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic [31:0] pc;
    logic        uv;
    logic        ut;
    logic [31:0] upc;
    logic [31:0] utg;
    logic [31:0] exp_next;
    logic        exp_hit;
    logic        exp_tk;
  } vec_t;

  // loop at 0x100..0x10C, backward branch at 0x10C to 0x100
  localparam vec_t TRACE [10] = '{
    '{32'h100, 1'b0, 1'b0, 32'h0,   32'h0,   32'h104, 1'b0, 1'b0},
    '{32'h104, 1'b0, 1'b0, 32'h0,   32'h0,   32'h108, 1'b0, 1'b0},
    '{32'h108, 1'b0, 1'b0, 32'h0,   32'h0,   32'h10C, 1'b0, 1'b0},
    '{32'h10C, 1'b1, 1'b1, 32'h10C, 32'h100, 32'h110, 1'b0, 1'b0},
    '{32'h100, 1'b0, 1'b0, 32'h0,   32'h0,   32'h104, 1'b0, 1'b0},
    '{32'h104, 1'b0, 1'b0, 32'h0,   32'h0,   32'h108, 1'b0, 1'b0},
    '{32'h108, 1'b0, 1'b0, 32'h0,   32'h0,   32'h10C, 1'b0, 1'b0},
    '{32'h10C, 1'b0, 1'b0, 32'h0,   32'h0,   32'h100, 1'b1, 1'b1},
    '{32'h100, 1'b1, 1'b0, 32'h10C, 32'h0,   32'h104, 1'b0, 1'b0},
    '{32'h10C, 1'b0, 1'b0, 32'h0,   32'h0,   32'h110, 1'b0, 1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic psh, input logic pp,
                       input logic uv, input logic ut, input logic [31:0] upc,
                       input logic [31:0] utg, input logic fl);
    fetch_pc = pc; call_push = psh; ret_pop = pp;
    upd_valid = uv; upd_taken = ut; upd_pc = upd_pc_sel(upc); upd_target = utg; flush = fl;
    #1;
  endtask

  function automatic logic [31:0] upd_pc_sel(input logic [31:0] v);
    return v;
  endfunction

  task automatic adv;
    @(negedge clk);
  endtask

  // one update-only cycle at an unrelated fetch address
  task automatic train(input logic [31:0] upc, input logic ut, input logic [31:0] utg);
    drive(32'hF000, 1'b0, 1'b0, 1'b1, ut, upc, utg, 1'b0); adv;
  endtask

  task automatic look(input logic [31:0] pc, input logic [31:0] exp_next,
                      input logic exp_hit, input string req);
    drive(pc, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, exp_next, req);
    chk({31'b0, pred_btb_hit}, {31'b0, exp_hit}, req);
    adv;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  localparam logic [31:0] A = 32'h400, B = 32'h800, C = 32'hC00, D = 32'h2000;
  localparam logic [31:0] X = 32'h3010;

  initial begin
    rst_n = 1'b0;
    drive(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    drive(32'h10C, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h110, "R1 next/empty-pop");
    chk({pred_btb_hit, pred_taken, pred_from_ras}, 3'b000, "R1 flags");
    adv;

    // loop trace: R2 R3 R5 R7
    foreach (TRACE[i]) begin
      drive(TRACE[i].pc, 1'b0, 1'b0, TRACE[i].uv, TRACE[i].ut, TRACE[i].upc, TRACE[i].utg, 1'b0);
      chk(pred_next_pc, TRACE[i].exp_next, "R2/R3 trace next");
      chk({30'b0, pred_btb_hit, pred_taken}, {30'b0, TRACE[i].exp_hit, TRACE[i].exp_tk},
          "R5/R7 trace hit/taken");
      adv;
    end

    // R4 set conflict and LRU (A, B, C share set 0)
    train(A, 1'b1, 32'hA0);
    train(B, 1'b1, 32'hB0);
    look(A, 32'hA0, 1'b1, "R4 A kept");
    look(B, 32'hB0, 1'b1, "R4 B kept");
    train(A, 1'b1, 32'hA0);           // A most recent
    train(C, 1'b1, 32'hC0);           // evicts B
    look(A, 32'hA0, 1'b1, "R4 A survives");
    look(C, 32'hC0, 1'b1, "R4 C allocated");
    look(B, B + 4, 1'b0, "R4 B evicted");

    // R12 destination replaced
    train(A, 1'b1, 32'hA8);
    look(A, 32'hA8, 1'b1, "R12 new target");

    // R5 not-taken invalidates, neighbour kept
    train(A, 1'b0, 32'h0);
    look(A, A + 4, 1'b0, "R5 invalidated");
    look(C, 32'hC0, 1'b1, "R5 other way kept");

    // R6 flush beats same-cycle allocation
    drive(32'hF000, 1'b0, 1'b0, 1'b1, 1'b1, D, 32'hD0, 1'b1); adv;
    look(D, D + 4, 1'b0, "R6 dropped update");
    look(C, C + 4, 1'b0, "R6 C flushed");

    // R7 counters: 1 -> 0 -> 0 -> 1
    train(X, 1'b0, 32'h0);
    train(X, 1'b0, 32'h0);
    train(X, 1'b1, 32'h90);
    drive(32'hF000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1); adv;
    drive(X, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk({30'b0, pred_btb_hit, pred_taken}, 32'd0, "R7 floor then one up");
    adv;
    train(X, 1'b1, 32'h90);           // 2
    drive(32'hF000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1); adv;
    drive(X, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk({30'b0, pred_btb_hit, pred_taken}, 32'd1, "R7 weakly taken on miss");
    adv;
    train(X, 1'b1, 32'h90);           // 3
    train(X, 1'b1, 32'h90);           // 3 saturated
    train(X, 1'b0, 32'h0);            // 2, entry invalidated
    drive(X, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk({30'b0, pred_btb_hit, pred_taken}, 32'd1, "R7 ceiling holds");
    chk(pred_next_pc, X + 4, "R5 R7 miss after not-taken");
    adv;

    // R8 LIFO and priority over a hit
    train(32'h40, 1'b1, 32'h80);
    drive(32'h500, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0); adv;
    drive(32'h600, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0); adv;
    drive(32'h40, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h604, "R8 pop newest over hit");
    chk({31'b0, pred_from_ras}, 32'd1, "R8 source flag");
    adv;
    drive(32'h900, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h504, "R8 pop older");
    adv;
    // R10 empty pop, even on a hit
    drive(32'h40, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h44, "R10 empty pop");
    chk({31'b0, pred_from_ras}, 32'd0, "R10 source flag");
    adv;

    // R9 overflow: 9 pushes, 8 newest come back
    for (int i = 0; i < 9; i++) begin
      drive(32'h1000 + 32'(i * 16), 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0); adv;
    end
    for (int i = 8; i >= 1; i--) begin
      drive(32'h900, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
      chk(pred_next_pc, 32'h1004 + 32'(i * 16), "R9 pop after overflow");
      adv;
    end
    drive(32'h900, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h904, "R9 R10 drained");
    adv;

    // R11 push and pop together
    drive(32'h700, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0); adv;
    drive(32'h710, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h704, "R11 predicts old top");
    adv;
    drive(32'h900, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h714, "R11 top replaced");
    adv;
    drive(32'h900, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk(pred_next_pc, 32'h904, "R11 depth unchanged");
    adv;

    finish_run();
  end
endmodule